// File: doc/BRIEF.md
# Sequential Restoring Divider with Divide-Check Abort

This block divides a double-length, sign-and-magnitude dividend by a single-length sign-and-magnitude divisor. The dividend's high magnitude comes from the accumulator and its low magnitude from the multiplier-quotient (MQ) register. The block produces one quotient bit per clock with a restoring shift-and-subtract loop. When the loop ends, the quotient goes to the MQ output and the remainder to the accumulator output.

Before it divides, the block compares the divisor magnitude against the accumulator magnitude. If the divisor is not strictly larger, the quotient could not fit in one word. In that case the block skips the loop and does three things in one cycle: it raises a sticky divide-check flag, pulses a halt request and completes the operation. The surrounding processor starts an operation with a one-cycle `start` pulse and waits for `done`.

Words are `MAG_W+1` bits wide. The top bit (index `MAG_W`) is the sign, where 1 means negative. Bits `MAG_W-1:0` hold the magnitude. The MQ input carries only a magnitude, because its sign has no part in the result.

Top module: `restoring_divider`

## Requirements
- R1: After reset `acc_out` and `mq_out` are zero and `div_check`, `halt` and `done` are low.
- R2: When `start` is accepted and the divisor magnitude `opnd_in[MAG_W-1:0]` is less than or equal to `acc_in[MAG_W-1:0]`, then on the next cycle:
  - `done` and `halt` are high for one cycle.
  - `div_check` is set.
  - `acc_out` equals `acc_in`.
  - `mq_out` holds `mq_mag_in`, with sign bit `acc_in[MAG_W] ^ opnd_in[MAG_W]`.
- R3: Otherwise the 2*MAG_W-bit dividend `{acc_in[MAG_W-1:0], mq_mag_in}` equals quotient magnitude × divisor magnitude + remainder magnitude, with the remainder strictly less than the divisor. The quotient magnitude appears in `mq_out[MAG_W-1:0]` and the remainder magnitude in `acc_out[MAG_W-1:0]`.
- R4: On a completed division, the sign bit of `acc_out` equals `acc_in[MAG_W]`, including for a zero remainder. The sign bit of `mq_out` equals `acc_in[MAG_W] ^ opnd_in[MAG_W]`.
- R5: A completed division raises `done` for exactly one cycle, MAG_W clock edges after the edge that accepted `start`, with `halt` low.
- R6: `halt` is high only on the cycle that completes an aborted operation.
- R7: `div_check` stays set through later operations until reset.
- R8: `start` pulses that arrive while a division is in progress are ignored. They produce no extra `done` and do not change the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| acc_in | input | MAG_W+1 | Accumulator: sign bit and high dividend magnitude |
| mq_mag_in | input | MAG_W | Low dividend magnitude |
| opnd_in | input | MAG_W+1 | Divisor: sign bit and magnitude |
| acc_out | output | MAG_W+1 | Remainder, or the unchanged accumulator on abort |
| mq_out | output | MAG_W+1 | Quotient, or the signed low magnitude on abort |
| div_check | output | 1 | Sticky divide-check flag |
| halt | output | 1 | One-cycle halt request on abort |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that:
- the abort condition produces the flag, the halt and the done pulse one cycle later;
- a legal start launches the loop;
- the divide-check flag never clears;
- `halt` never appears without `done`;
- a completed remainder is smaller than the latched divisor;
- the completion comes exactly MAG_W edges after acceptance.

Only the bench's scenarios can show that the quotient and remainder reconstruct the dividend and that the result signs follow the operand signs. The same holds for the boundary cases (divisor equal to, one above, or zero against the accumulator) and for starts issued mid-division being ignored.

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAG_W:0]   acc_in,
  input  logic [MAG_W-1:0] mq_mag_in,
  input  logic [MAG_W:0]   opnd_in,
  output logic [MAG_W:0]   acc_out,
  output logic [MAG_W:0]   mq_out,
  output logic             div_check,
  output logic             halt,
  output logic             done
);
  localparam int CW = $clog2(MAG_W + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [MAG_W-1:0] rem, quo, dvs;
  logic             rsgn, qsgn;

  logic             accept, too_big, fits, last;
  logic [MAG_W:0]   trial, diff;
  logic [MAG_W-1:0] nrem, nquo;

  assign accept  = start & ~busy;
  assign too_big = opnd_in[MAG_W-1:0] <= acc_in[MAG_W-1:0];
  assign trial   = {rem, quo[MAG_W-1]};
  assign fits    = trial >= {1'b0, dvs};
  assign diff    = trial - {1'b0, dvs};
  assign nrem    = fits ? diff[MAG_W-1:0] : trial[MAG_W-1:0];
  assign nquo    = {quo[MAG_W-2:0], fits};
  assign last    = cnt == CW'(MAG_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rem       <= '0;
      quo       <= '0;
      dvs       <= '0;
      rsgn      <= 1'b0;
      qsgn      <= 1'b0;
      acc_out   <= '0;
      mq_out    <= '0;
      div_check <= 1'b0;
      halt      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      halt <= 1'b0;
      if (accept) begin
        if (too_big) begin
          div_check <= 1'b1;
          halt      <= 1'b1;
          done      <= 1'b1;
          acc_out   <= acc_in;
          mq_out    <= {acc_in[MAG_W] ^ opnd_in[MAG_W], mq_mag_in};
        end else begin
          busy <= 1'b1;
          cnt  <= '0;
          rem  <= acc_in[MAG_W-1:0];
          quo  <= mq_mag_in;
          dvs  <= opnd_in[MAG_W-1:0];
          rsgn <= acc_in[MAG_W];
          qsgn <= acc_in[MAG_W] ^ opnd_in[MAG_W];
        end
      end else if (busy) begin
        rem <= nrem;
        quo <= nquo;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          acc_out <= {rsgn, nrem};
          mq_out  <= {qsgn, nquo};
        end
      end
    end
  end
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int MAG_W = 35
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [MAG_W-1:0] acc_mag,
  input logic [MAG_W-1:0] opnd_mag,
  input logic [MAG_W-1:0] rem_mag,
  input logic [MAG_W-1:0] dvs,
  input logic             div_check,
  input logic             halt,
  input logic             done
);
  localparam int CW = $clog2(MAG_W + 1);

  logic [CW-1:0] lat;
  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy) lat <= lat + 1'b1;
  end

  a_r2_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opnd_mag <= acc_mag) |=> (div_check && halt && done));

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opnd_mag > acc_mag) |=> (busy && !done));

  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !halt) |-> (rem_mag < dvs));

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !halt) |-> (lat == CW'(MAG_W)));

  a_r6_halt_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (done && div_check));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    div_check |=> div_check);

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind restoring_divider restoring_divider_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .acc_mag(acc_in[MAG_W-1:0]), .opnd_mag(opnd_in[MAG_W-1:0]),
  .rem_mag(acc_out[MAG_W-1:0]), .dvs(dvs),
  .div_check(div_check), .halt(halt), .done(done)
);

// File: tb/sim_restoring_divider.sv
`timescale 1ns/1ps
module sim_restoring_divider;
  localparam int MAG_W = 35;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [MAG_W:0]   acc_in = '0;
  logic [MAG_W-1:0] mq_mag_in = '0;
  logic [MAG_W:0]   opnd_in = '0;
  logic [MAG_W:0]   acc_out, mq_out;
  logic             div_check, halt, done;

  always #2.5 clk = ~clk;

  restoring_divider #(.MAG_W(MAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
    .mq_mag_in(mq_mag_in), .opnd_in(opnd_in), .acc_out(acc_out),
    .mq_out(mq_out), .div_check(div_check), .halt(halt), .done(done)
  );

  typedef struct {
    logic [MAG_W:0] acc;
    logic [MAG_W:0] mq;
    logic           hlt;
    logic           dchk;
    int             issue;
    int             lat;
    string          tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests = 0, fails = 0, cyc = 0;
  logic model_dchk = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MAG_W:0] act, input logic [MAG_W:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected done", {35'd0, done}, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(acc_out == e.acc, e.tag, "acc_out", acc_out, e.acc);
        check(mq_out == e.mq, e.tag, "mq_out", mq_out, e.mq);
        check(halt == e.hlt, e.hlt ? "R2" : "R6", "halt", {35'd0, halt}, {35'd0, e.hlt});
        check(div_check == e.dchk, "R7", "div_check", {35'd0, div_check}, {35'd0, e.dchk});
        check((cyc - e.issue) == e.lat, e.hlt ? "R2" : "R5", "latency",
              (MAG_W+1)'(cyc - e.issue), (MAG_W+1)'(e.lat));
      end
    end
  end

  task automatic run_div(input logic [MAG_W:0] a, input logic [MAG_W-1:0] m,
                         input logic [MAG_W:0] d, input string tag, input bit poke);
    exp_t e;
    logic [2*MAG_W-1:0] dividend, q, r;
    e.tag = tag;
    if (d[MAG_W-1:0] <= a[MAG_W-1:0]) begin
      model_dchk = 1'b1;
      e.acc = a;
      e.mq  = {a[MAG_W] ^ d[MAG_W], m};
      e.hlt = 1'b1;
      e.lat = 1;
    end else begin
      dividend = {a[MAG_W-1:0], m};
      q = dividend / {35'd0, d[MAG_W-1:0]};
      r = dividend % {35'd0, d[MAG_W-1:0]};
      e.acc = {a[MAG_W], r[MAG_W-1:0]};
      e.mq  = {a[MAG_W] ^ d[MAG_W], q[MAG_W-1:0]};
      e.hlt = 1'b0;
      e.lat = MAG_W + 1;
    end
    e.dchk = model_dchk;
    @(negedge clk);
    acc_in = a; mq_mag_in = m; opnd_in = d; start = 1'b1;
    e.issue = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      acc_in = '0; mq_mag_in = '1; opnd_in = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [MAG_W-1:0] ONES = '1;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_out == '0, "R1", "acc_out after reset", acc_out, '0);
    check(mq_out == '0, "R1", "mq_out after reset", mq_out, '0);
    check({div_check, halt, done} == 3'b000, "R1", "flags after reset",
          {33'd0, div_check, halt, done}, '0);

    run_div({1'b0, 35'd0}, 35'd100, {1'b0, 35'd7}, "R3", 1'b0);
    run_div({1'b1, 35'd3}, 35'd12345, {1'b0, 35'd10}, "R4", 1'b0);
    run_div({1'b0, 35'd3}, 35'd12345, {1'b1, 35'd10}, "R4", 1'b0);
    run_div({1'b1, 35'd3}, 35'd12345, {1'b1, 35'd10}, "R4", 1'b0);
    run_div({1'b1, 35'd0}, 35'd40, {1'b0, 35'd8}, "R4", 1'b0);
    run_div({1'b0, ONES - 35'd1}, ONES, {1'b0, ONES}, "R3", 1'b0);
    run_div({1'b0, 35'd500}, 35'd77, {1'b0, 35'd501}, "R3", 1'b0);
    run_div({1'b0, 35'd1000}, 35'd999, {1'b0, 35'd1234567}, "R8", 1'b1);
    check(div_check == 1'b0, "R7", "div_check before any abort", {35'd0, div_check}, '0);

    run_div({1'b0, 35'd500}, 35'd77, {1'b0, 35'd500}, "R2", 1'b0);
    run_div({1'b1, 35'd9}, 35'd5, {1'b0, 35'd0}, "R2", 1'b0);
    run_div({1'b0, 35'd900}, 35'd6, {1'b1, 35'd12}, "R2", 1'b0);
    run_div({1'b1, 35'd900}, 35'd6, {1'b1, 35'd12}, "R2", 1'b0);
    run_div({1'b0, 35'd2}, 35'd50, {1'b0, 35'd9}, "R7", 1'b0);
    check(div_check == 1'b1, "R7", "div_check held after normal op", {35'd0, div_check}, {35'd0, 1'b1});
    check(halt == 1'b0 && done == 1'b0, "R6", "halt idle", {34'd0, halt, done}, '0);

    for (int i = 0; i < 40; i++) begin
      logic [63:0] rd, ra, rm;
      logic [MAG_W-1:0] dm, am;
      rd = {$urandom(), $urandom()};
      ra = {$urandom(), $urandom()};
      rm = {$urandom(), $urandom()};
      dm = rd[MAG_W-1:0];
      if (i % 3 == 0) dm = dm >> (i % 30);
      if (dm == '0) dm = 35'd1;
      am = ra[MAG_W-1:0] % dm;
      run_div({ra[40], am}, rm[MAG_W-1:0], {rd[50], dm}, "R3", i % 10 == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule